// File: doc/BRIEF.md
# Glitch-Free Base Clock Source Selector

This block chooses the source of a base clock. The source is either a reference crystal clock or the clock from a PLL's voltage-controlled oscillator. The choice comes from a small control register written in the crystal clock domain. That register holds a PLL-enable bit, a source-select bit, a multiplier value and a loop divider value. Write interlocks keep the register in a consistent state. The VCO can only be chosen while the PLL is on. The PLL cannot be turned off while it drives the clock. The PLL-enable bit and the source select cannot both change in one write. A zero loop divider disables the PLL and forces the crystal.

A source change runs as a handshake between the two clock domains. Each domain passes its enable request through a two-flop synchronizer and then through a gating flop clocked on the falling edge. The old source is shut off first. The new source is enabled only after that. While the handover runs, the merged clock sits low and has no edges, and a busy flag is raised. The merged clock is divided by two to form a 50% duty base clock. The base clock is divided by two again to form the bus clock. The bus clock therefore runs at one quarter of the selected source.

The control pins are plain strobes and levels. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `clksel_top`

## Requirements
- R1: After an asynchronous active-low reset, the PLL-enable bit is 0, the select bit is 0 (crystal), the PLL counts as disabled, the crystal drives the output (vco_active = 0) and busy is 0.
- R2: The base clock period is two periods of the active source and the bus clock period is four periods of the active source, for both sources.
- R3: A write with select = 1 (VCO) while the stored PLL-enable bit is 0 leaves the select bit at 0.
- R4: A write with PLL-enable = 0 while the select bit is 1 leaves the PLL-enable bit at 1.
- R5: In a write whose PLL-enable value differs from the stored one, the select bit keeps its stored value.
- R6: If the loop divider is zero, pll_enable is 0 and the select bit cannot be 1. A write that sets the divider to zero while the VCO is selected returns the select bit and the active source to the crystal.
- R7: The effective multiplier output equals the stored multiplier, except that a stored 0 reads as 1.
- R8: The two source gates are never open at the same time. busy is 1 from the select change until the new source drives the output, and no base clock edge comes closer to the previous one than one period of the faster source.
- R9: A source change completes within three crystal periods plus three VCO periods, plus one crystal period of write alignment, and vco_active then matches the select bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xclk | input | 1 | Crystal reference clock; also clocks the control register |
| vclk | input | 1 | VCO clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe, sampled on xclk rising edge |
| wr_pll_on | input | 1 | Requested PLL-enable value |
| wr_sel_vco | input | 1 | Requested source: 1 = VCO, 0 = crystal |
| wr_mul | input | MUL_W | Multiplier value to store |
| wr_ldiv | input | LDIV_W | Loop divider value to store |
| pll_on | output | 1 | Stored PLL-enable bit |
| sel_vco | output | 1 | Stored source-select bit |
| pll_enable | output | 1 | PLL truly enabled (enable bit set and divider nonzero) |
| mul_eff | output | MUL_W | Effective multiplier (0 read as 1) |
| ldiv | output | LDIV_W | Stored loop divider |
| base_clk | output | 1 | Selected source divided by two |
| bus_clk | output | 1 | Base clock divided by two |
| vco_active | output | 1 | 1 when the VCO gate is open and drives the output |
| busy | output | 1 | A source change is in progress |

## Verification
The clock path is checked on a crystal clock and a VCO clock of different, non-related periods. Because the periods differ, a bus period of four crystal periods shows which source is active, and so does a bus period of four VCO periods. Switches are made in both directions, and once more when a zero divider write forces the change. During each switch the gap between base clock edges is watched, which exposes any glitch. The length of the busy interval is also measured. For the register, writes are made that hit each interlock alone, and also writes that try to change the PLL-enable and select bits together from both stored states. These show whether a refusal comes from the PLL-enable rule, the select rule or the divider rule.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
package clksel_pkg;
  typedef enum logic {SRC_XTAL = 1'b0, SRC_VCO = 1'b1} src_e;
endpackage

// File: rtl/clksel_regs.sv
`timescale 1ns/1ps
module clksel_regs
  import clksel_pkg::*;
#(
  parameter int MUL_W  = 12,
  parameter int LDIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_pll_on,
  input  logic              wr_sel_vco,
  input  logic [MUL_W-1:0]  wr_mul,
  input  logic [LDIV_W-1:0] wr_ldiv,
  output logic              pll_on,
  output src_e              sel,
  output logic              pll_enable,
  output logic [MUL_W-1:0]  mul_eff,
  output logic [LDIV_W-1:0] ldiv
);
  localparam logic [MUL_W-1:0] MUL_ONE = MUL_W'(1);

  logic [MUL_W-1:0] mul_q;
  logic             pll_flip, nxt_pll, sel_try;
  src_e             nxt_sel;

  always_comb begin
    pll_flip = (wr_pll_on != pll_on);
    // PLL may not go off while it drives the clock
    nxt_pll  = (sel == SRC_VCO && !wr_pll_on) ? 1'b1 : wr_pll_on;
    // a PLL-enable change freezes the select; VCO needs the PLL already on
    sel_try  = pll_flip ? (sel == SRC_VCO) : (wr_sel_vco & pll_on);
    nxt_sel  = (sel_try && (wr_ldiv != '0)) ? SRC_VCO : SRC_XTAL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pll_on <= 1'b0;
      sel    <= SRC_XTAL;
      mul_q  <= '0;
      ldiv   <= '0;
    end else if (wr_en) begin
      pll_on <= nxt_pll;
      sel    <= nxt_sel;
      mul_q  <= wr_mul;
      ldiv   <= wr_ldiv;
    end
  end

  assign pll_enable = pll_on & (|ldiv);
  assign mul_eff    = (mul_q == '0) ? MUL_ONE : mul_q;
endmodule

// File: rtl/clksel_gate.sv
`timescale 1ns/1ps
module clksel_gate #(
  parameter int SYNC_STAGES = 2,
  parameter bit RST_ON      = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic other_on,
  output logic on,
  output logic gclk
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   req;

  assign req = want & ~other_on;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= RST_ON;
        else        sync_q <= req;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= {SYNC_STAGES{RST_ON}};
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], req};
    end
  endgenerate

  // gate changes only while the clock is low
  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) on <= RST_ON;
    else        on <= sync_q[SYNC_STAGES-1];

  assign gclk = clk & on;
endmodule

// File: rtl/clksel_div.sv
`timescale 1ns/1ps
module clksel_div (
  input  logic mclk,
  input  logic rst_n,
  output logic base_clk,
  output logic bus_clk
);
  always_ff @(posedge mclk or negedge rst_n)
    if (!rst_n) base_clk <= 1'b0;
    else        base_clk <= ~base_clk;

  always_ff @(posedge base_clk or negedge rst_n)
    if (!rst_n) bus_clk <= 1'b0;
    else        bus_clk <= ~bus_clk;
endmodule

// File: rtl/clksel_top.sv
`timescale 1ns/1ps
module clksel_top
  import clksel_pkg::*;
#(
  parameter int MUL_W       = 12,
  parameter int LDIV_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              xclk,
  input  logic              vclk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_pll_on,
  input  logic              wr_sel_vco,
  input  logic [MUL_W-1:0]  wr_mul,
  input  logic [LDIV_W-1:0] wr_ldiv,
  output logic              pll_on,
  output logic              sel_vco,
  output logic              pll_enable,
  output logic [MUL_W-1:0]  mul_eff,
  output logic [LDIV_W-1:0] ldiv,
  output logic              base_clk,
  output logic              bus_clk,
  output logic              vco_active,
  output logic              busy
);
  src_e sel;
  logic want_vco, x_on, v_on, x_gclk, v_gclk, mclk;

  clksel_regs #(.MUL_W(MUL_W), .LDIV_W(LDIV_W)) u_regs (
    .clk(xclk), .rst_n(rst_n), .wr_en(wr_en), .wr_pll_on(wr_pll_on),
    .wr_sel_vco(wr_sel_vco), .wr_mul(wr_mul), .wr_ldiv(wr_ldiv),
    .pll_on(pll_on), .sel(sel), .pll_enable(pll_enable),
    .mul_eff(mul_eff), .ldiv(ldiv)
  );

  assign want_vco = (sel == SRC_VCO) & pll_enable;
  assign sel_vco  = (sel == SRC_VCO);

  clksel_gate #(.SYNC_STAGES(SYNC_STAGES), .RST_ON(1'b1)) u_xgate (
    .clk(xclk), .rst_n(rst_n), .want(~want_vco), .other_on(v_on),
    .on(x_on), .gclk(x_gclk)
  );

  clksel_gate #(.SYNC_STAGES(SYNC_STAGES), .RST_ON(1'b0)) u_vgate (
    .clk(vclk), .rst_n(rst_n), .want(want_vco), .other_on(x_on),
    .on(v_on), .gclk(v_gclk)
  );

  assign mclk = x_gclk | v_gclk;

  clksel_div u_div (.mclk(mclk), .rst_n(rst_n), .base_clk(base_clk), .bus_clk(bus_clk));

  assign vco_active = v_on;
  assign busy       = want_vco ? (x_on | ~v_on) : (v_on | ~x_on);
endmodule

// File: rtl/clksel_chk.sv
`timescale 1ns/1ps
module clksel_chk #(
  parameter int MUL_W  = 12,
  parameter int LDIV_W = 8
) (
  input logic              xclk,
  input logic              vclk,
  input logic              rst_n,
  input logic              pll_on,
  input logic              sel_vco,
  input logic              pll_enable,
  input logic [MUL_W-1:0]  mul_eff,
  input logic [LDIV_W-1:0] ldiv,
  input logic              x_on,
  input logic              v_on
);
  assert_vco_needs_pll_R3: assert property (@(posedge xclk) disable iff (!rst_n)
    sel_vco |-> pll_on);
  assert_pll_held_R4: assert property (@(posedge xclk) disable iff (!rst_n)
    sel_vco |=> pll_on);
  assert_no_dual_change_R5: assert property (@(posedge xclk) disable iff (!rst_n)
    (pll_on != $past(pll_on)) |-> (sel_vco == $past(sel_vco)));
  assert_ldiv_forces_xtal_R6: assert property (@(posedge xclk) disable iff (!rst_n)
    (ldiv == '0) |-> (!sel_vco && !pll_enable));
  assert_mul_nonzero_R7: assert property (@(posedge xclk) disable iff (!rst_n)
    mul_eff != '0);
  assert_gates_exclusive_x_R8: assert property (@(posedge xclk) disable iff (!rst_n)
    !(x_on && v_on));
  assert_gates_exclusive_v_R8: assert property (@(posedge vclk) disable iff (!rst_n)
    !(x_on && v_on));
endmodule

bind clksel_top clksel_chk #(.MUL_W(MUL_W), .LDIV_W(LDIV_W)) u_chk (
  .xclk(xclk), .vclk(vclk), .rst_n(rst_n), .pll_on(pll_on), .sel_vco(sel_vco),
  .pll_enable(pll_enable), .mul_eff(mul_eff), .ldiv(ldiv),
  .x_on(x_on), .v_on(v_on)
);

// File: tb/tb_clksel_top.sv
`timescale 1ns/1ps
module tb_clksel_top;
  localparam real CLK_PERIOD = 10.0;
  localparam real VCO_PERIOD = 6.0;
  localparam int  MUL_W = 12;
  localparam int  LDIV_W = 8;

  logic xclk = 0, vclk = 0, rst_n = 0;
  logic wr_en = 0, wr_pll_on = 0, wr_sel_vco = 0;
  logic [MUL_W-1:0]  wr_mul = '0;
  logic [LDIV_W-1:0] wr_ldiv = '0;
  logic pll_on, sel_vco, pll_enable, base_clk, bus_clk, vco_active, busy;
  logic [MUL_W-1:0]  mul_eff;
  logic [LDIV_W-1:0] ldiv;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) xclk = ~xclk;
  always #(VCO_PERIOD/2) vclk = ~vclk;

  clksel_top #(.MUL_W(MUL_W), .LDIV_W(LDIV_W)) dut (
    .xclk(xclk), .vclk(vclk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_pll_on(wr_pll_on), .wr_sel_vco(wr_sel_vco), .wr_mul(wr_mul),
    .wr_ldiv(wr_ldiv), .pll_on(pll_on), .sel_vco(sel_vco),
    .pll_enable(pll_enable), .mul_eff(mul_eff), .ldiv(ldiv),
    .base_clk(base_clk), .bus_clk(bus_clk), .vco_active(vco_active), .busy(busy)
  );

  // base clock edge spacing monitor
  realtime last_edge = 0.0, min_gap = 1.0e9;
  always @(base_clk) begin
    if ($realtime - last_edge < min_gap) min_gap = $realtime - last_edge;
    last_edge = $realtime;
  end

  task automatic check(input string req, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_real(input string req, input realtime act, input realtime lo, input realtime hi);
    n_tests++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s actual=%0.3f expected %0.3f..%0.3f", req, act, lo, hi);
    end
  endtask

  task automatic write(input logic p, input logic s, input int m, input int l);
    @(negedge xclk);
    wr_en = 1; wr_pll_on = p; wr_sel_vco = s;
    wr_mul = MUL_W'(m); wr_ldiv = LDIV_W'(l);
    @(negedge xclk);
    wr_en = 0;
  endtask

  task automatic measure_periods(input string req, input realtime src);
    realtime t1, t2;
    @(posedge base_clk); t1 = $realtime;
    @(posedge base_clk); t2 = $realtime;
    check_real({req, " base period"}, t2 - t1, 2*src - 0.01, 2*src + 0.01);
    @(posedge bus_clk); t1 = $realtime;
    @(posedge bus_clk); t2 = $realtime;
    check_real({req, " bus period"}, t2 - t1, 4*src - 0.01, 4*src + 0.01);
  endtask

  // a write was just issued that should start a switch; watch it finish
  task automatic follow_switch(input string req, input logic exp_vco);
    realtime t0, dt;
    t0 = $realtime;
    check({req, " busy raised"}, busy, 1);
    min_gap = 1.0e9;
    wait (busy == 0);
    dt = $realtime - t0;
    check_real({req, " R9 switch time"}, dt, 0.0, 4*CLK_PERIOD + 3*VCO_PERIOD);
    repeat (2) @(posedge base_clk);
    check_real({req, " R8 min base edge gap"}, min_gap, VCO_PERIOD - 0.01, 1.0e9);
    @(negedge xclk);
    check({req, " R9 vco_active"}, vco_active, exp_vco);
  endtask

  task automatic t_reset;
    check("R1 pll_on", pll_on, 0);
    check("R1 sel_vco", sel_vco, 0);
    check("R1 pll_enable", pll_enable, 0);
    check("R1 vco_active", vco_active, 0);
    check("R1 busy", busy, 0);
    measure_periods("R2 crystal", CLK_PERIOD);
  endtask

  task automatic t_sel_without_pll;
    write(0, 1, 8, 'h45);
    check("R3 sel refused", sel_vco, 0);
    check("R3 pll_on", pll_on, 0);
    check("R3 vco_active", vco_active, 0);
  endtask

  task automatic t_dual_change_on;
    write(1, 1, 8, 'h45);
    check("R5 pll on accepted", pll_on, 1);
    check("R5 sel frozen", sel_vco, 0);
    check("R5 pll_enable", pll_enable, 1);
    check("R5 busy idle", busy, 0);
  endtask

  task automatic t_to_vco;
    write(1, 1, 8, 'h45);
    check("R8 sel vco", sel_vco, 1);
    follow_switch("R8 to vco", 1);
    measure_periods("R2 vco", VCO_PERIOD);
  endtask

  task automatic t_pll_off_refused;
    write(0, 1, 8, 'h45);
    check("R4 pll held", pll_on, 1);
    check("R4 sel kept", sel_vco, 1);
    write(0, 0, 8, 'h45);
    check("R4 pll held on dual", pll_on, 1);
    check("R5 sel frozen on dual", sel_vco, 1);
    check("R4 vco still active", vco_active, 1);
  endtask

  task automatic t_to_xtal;
    write(1, 0, 8, 'h45);
    check("R8 sel xtal", sel_vco, 0);
    follow_switch("R8 to xtal", 0);
    measure_periods("R2 crystal again", CLK_PERIOD);
  endtask

  task automatic t_ldiv_zero;
    write(1, 1, 8, 0);
    check("R6 sel refused L=0", sel_vco, 0);
    check("R6 pll_enable L=0", pll_enable, 0);
    write(1, 1, 8, 'h45);
    check("R6 sel with L", sel_vco, 1);
    follow_switch("R6 up", 1);
    write(1, 1, 8, 0);
    check("R6 forced xtal", sel_vco, 0);
    follow_switch("R6 forced", 0);
  endtask

  task automatic t_mul_zero;
    write(1, 0, 0, 'h45);
    check("R7 zero reads one", mul_eff, 1);
    write(1, 0, 'h1c, 'h45);
    check("R7 plain value", mul_eff, 'h1c);
    write(0, 0, 'h1c, 'h45);
    check("R4 pll off when xtal", pll_on, 0);
  endtask

  initial begin
    #(200000*CLK_PERIOD);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(3*CLK_PERIOD + 1.0);
    rst_n = 1;
    repeat (4) @(negedge xclk);
    t_reset;
    t_sel_without_pll;
    t_dual_change_on;
    t_to_vco;
    t_pll_off_refused;
    t_to_xtal;
    t_ldiv_zero;
    t_mul_zero;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule